// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block sits between a small set of external interrupt pins and whatever consumes interrupt requests, such as a processor input or a request aggregator. It produces one request line per pin. Each pin is brought into the clock domain through two flip-flops. It is then judged by its own trigger mode: active-high level, active-low level, rising edge, falling edge, or both edges. Edge events are held in a per-pin latch until software acknowledges them. A per-pin enable bit gates each request.

Software sees the configuration as 32-bit words. Each word holds four pin slots, so pin `p` belongs to word `p/4`, slot `p mod 4`. Within a word, each field holds four bits, one per slot, and slot `s` sits at bit `s` of the field:

| Field | Bits | Meaning |
|---|---|---|
| enable | [3:0] | request passes only when the bit is 1 |
| acknowledge | [7:4] | write-only; always reads back as 0 |
| polarity | [11:8] | 1 = high level / rising edge, 0 = low level / falling edge |
| any-edge | [15:12] | 1 = both edges |
| level | [19:16] | 1 = level mode |

All other bits, and slots beyond the last pin, read as 0. The ports are plain control pins with no handshake. A write takes effect on the clock edge where `cfg_wr_en` is high, and reads are combinational.

Top module: `ext_trigger_unit`

## Requirements
- R1: After reset, every configuration word reads 0, so every pin is in falling-edge mode with its enable bit at 0, and every request output is 0.
- R2: Configuration for pin p is held in word p/4 at slot p mod 4, using the field layout given above. Acknowledge bits, unused bits and slots beyond the last pin read back as 0. A write to one word leaves the other word unchanged.
- R3: With level=0 and any-edge=0, polarity=1 latches a rising edge and polarity=0 latches a falling edge. The opposite edge sets nothing. A latched event stays set after the pin returns to its previous level.
- R4: With level=0 and any-edge=1, both rising and falling edges latch an event.
- R5: With level=1, the request follows the synchronized pin and nothing is latched. Polarity=1 means active-high and polarity=0 means active-low; the any-edge bit is ignored.
- R6: A pin's request is asserted only when its enable bit is 1. An event latched while the enable bit is 0 appears on the request output once the enable bit is set.
- R7: Writing 1 to a pin's acknowledge bit clears that pin's latched event. Latches of other pins, and latches whose acknowledge bit is written as 0, are left unchanged.
- R8: In level mode, an acknowledge write has no effect on the request.
- R9: In level mode, a pin change appears on the request two clock edges after the pin changes. In edge mode, it appears three clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| pins_i | input | NPINS | raw external interrupt pins |
| cfg_wr_en | input | 1 | configuration write strobe |
| cfg_wr_sel | input | SEL_W | index of the word being written |
| cfg_wr_data | input | 32 | write data |
| cfg_rd_sel | input | SEL_W | index of the word being read |
| cfg_rd_data | output | 32 | read data (combinational) |
| irq_o | output | NPINS | one request line per pin |

## Verification
A level result is due two clock edges after the pin changes: one edge for each synchronizer stage. An edge result takes one more edge, because the previous-level register and the latch add a stage. An acknowledge takes effect one edge after the write edge. The bench drives all inputs on falling clock edges and counts rising edges before it samples. Latency is checked at the exact boundary: the request must still be low one edge early and must be high on the due edge. Functional checks wait several edges so that they do not depend on this timing.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int SLOTS     = 4;
  localparam int REG_W     = 32;
  localparam int EN_LSB    = 0;
  localparam int ACK_LSB   = 4;
  localparam int POL_LSB   = 8;
  localparam int ANY_LSB   = 12;
  localparam int LVL_LSB   = 16;

  typedef struct packed {
    logic level;
    logic pol;
    logic any;
  } trig_mode_t;
endpackage

// File: rtl/trig_sync2.sv
module trig_sync2 #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int SEL_W = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [REG_W-1:0]       rd_data,
  output trig_mode_t [NPINS-1:0] mode_o,
  output logic [NPINS-1:0]       en_o,
  output logic [NPINS-1:0]       ack_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int WORD = p / SLOTS;
    localparam int SLOT = p % SLOTS;
    logic       hit;
    logic       en_q;
    logic       ack_q;
    trig_mode_t mode_q;

    assign hit = wr_en && (wr_sel == SEL_W'(WORD));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        mode_q <= '0;
        ack_q  <= 1'b0;
      end else begin
        ack_q <= hit && wr_data[ACK_LSB + SLOT];
        if (hit) begin
          en_q         <= wr_data[EN_LSB  + SLOT];
          mode_q.pol   <= wr_data[POL_LSB + SLOT];
          mode_q.any   <= wr_data[ANY_LSB + SLOT];
          mode_q.level <= wr_data[LVL_LSB + SLOT];
        end
      end
    end

    assign en_o[p]   = en_q;
    assign mode_o[p] = mode_q;
    assign ack_o[p]  = ack_q;

    // An acknowledge pulse only follows a write to this pin's word
    AST_ACK_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> ($past(wr_en) && $past(wr_sel) == SEL_W'(WORD))); // R7
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (rd_sel == SEL_W'(p / SLOTS)) begin
        rd_data[EN_LSB  + (p % SLOTS)] = en_o[p];
        rd_data[POL_LSB + (p % SLOTS)] = mode_o[p].pol;
        rd_data[ANY_LSB + (p % SLOTS)] = mode_o[p].any;
        rd_data[LVL_LSB + (p % SLOTS)] = mode_o[p].level;
      end
    end
  end
endmodule

// File: rtl/trig_pin_detect.sv
module trig_pin_detect
  import trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  trig_mode_t mode_i,
  input  logic       en_i,
  input  logic       ack_i,
  output logic       req_o
);
  logic prev_q;
  logic held_q;
  logic rise, fall, edge_hit, held_d;

  assign rise     = sync_i & ~prev_q;
  assign fall     = ~sync_i & prev_q;
  assign edge_hit = mode_i.any ? (rise | fall) : (mode_i.pol ? rise : fall);
  assign held_d   = mode_i.level ? 1'b0 : ((held_q & ~ack_i) | edge_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      held_q <= held_d;
    end
  end

  assign req_o = en_i & (mode_i.level ? (mode_i.pol ? sync_i : ~sync_i) : held_q);

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i.level && edge_hit) |=> held_q); // R3

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i.level && ack_i && !edge_hit) |=> !held_q); // R7

  AST_HOLD_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i.level && held_q && !ack_i) |=> held_q); // R7

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i.level && $past(mode_i.level)) |-> !held_q); // R5
endmodule

// File: rtl/ext_trigger_unit.sv
module ext_trigger_unit
  import trig_pkg::*;
#(
  parameter  int NPINS = 6,
  localparam int NWORDS = (NPINS + SLOTS - 1) / SLOTS,
  localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             cfg_wr_en,
  input  logic [SEL_W-1:0] cfg_wr_sel,
  input  logic [REG_W-1:0] cfg_wr_data,
  input  logic [SEL_W-1:0] cfg_rd_sel,
  output logic [REG_W-1:0] cfg_rd_data,
  output logic [NPINS-1:0] irq_o
);
  logic [NPINS-1:0]       sync_w;
  trig_mode_t [NPINS-1:0] mode_w;
  logic [NPINS-1:0]       en_w;
  logic [NPINS-1:0]       ack_w;

  trig_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(sync_w)
  );

  trig_cfg_regs #(.NPINS(NPINS), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .rd_sel(cfg_rd_sel), .rd_data(cfg_rd_data),
    .mode_o(mode_w), .en_o(en_w), .ack_o(ack_w)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_det
    trig_pin_detect u_det (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_w[p]), .mode_i(mode_w[p]),
      .en_i(en_w[p]), .ack_i(ack_w[p]), .req_o(irq_o[p])
    );
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~en_w) == '0); // R6
endmodule

// File: tb/ext_trigger_unit_tb.sv
module ext_trigger_unit_tb;
  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [0:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [NP-1:0] irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [31:0] img [2];

  always #5 clk = ~clk;

  ext_trigger_unit #(.NPINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins),
    .cfg_wr_en(wr_en), .cfg_wr_sel(wr_sel), .cfg_wr_data(wr_data),
    .cfg_rd_sel(rd_sel), .cfg_rd_data(rd_data), .irq_o(irq)
  );

  // entry: {pin[2:0], level, pol, any, from, to, expected}
  localparam logic [8:0] VEC [12] = '{
    {3'd0, 3'b000, 1'b1, 1'b0, 1'b1},  // R3 falling, falls
    {3'd0, 3'b000, 1'b0, 1'b1, 1'b0},  // R3 falling, rises
    {3'd1, 3'b010, 1'b0, 1'b1, 1'b1},  // R3 rising, rises
    {3'd1, 3'b010, 1'b1, 1'b0, 1'b0},  // R3 rising, falls
    {3'd2, 3'b001, 1'b0, 1'b1, 1'b1},  // R4 any edge, rises
    {3'd2, 3'b001, 1'b1, 1'b0, 1'b1},  // R4 any edge, falls
    {3'd3, 3'b110, 1'b0, 1'b1, 1'b1},  // R5 high level, high
    {3'd3, 3'b110, 1'b1, 1'b0, 1'b0},  // R5 high level, low
    {3'd4, 3'b100, 1'b1, 1'b0, 1'b1},  // R5 low level, low
    {3'd4, 3'b100, 1'b0, 1'b1, 1'b0},  // R5 low level, high
    {3'd5, 3'b010, 1'b0, 1'b1, 1'b1},  // R3 rising on word 1
    {3'd5, 3'b001, 1'b0, 1'b0, 1'b0}   // R4 no edge, nothing
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel[0:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_pin(input int p, input logic l, input logic s, input logic a, input logic e);
    int w; int k;
    w = p / 4; k = p % 4;
    img[w][k] = e; img[w][8+k] = s; img[w][12+k] = a; img[w][16+k] = l;
    wr(w, img[w]);
  endtask

  task automatic ack_pin(input int p);
    wr(p / 4, img[p / 4] | (32'd1 << (4 + p % 4)));
  endtask

  task automatic rd(input int sel, output logic [31:0] v);
    rd_sel = sel[0:0];
    #1 v = rd_data;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    img[0] = '0; img[1] = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(32'(irq), 32'h0, "R1 irq after reset");
    rd(0, v); chk(v, 32'h0, "R1 word0 after reset");
    rd(1, v); chk(v, 32'h0, "R1 word1 after reset");

    // table-driven modes
    foreach (VEC[i]) begin
      int p;
      p = int'(VEC[i][8:6]);
      set_pin(p, VEC[i][5], VEC[i][4], VEC[i][3], 1'b1);
      pins[p] = VEC[i][2];
      step(4);
      ack_pin(p);
      step(1);
      pins[p] = VEC[i][1];
      step(4);
      chk(32'(irq[p]), 32'(VEC[i][0]), $sformatf("R3/R4/R5 vector %0d", i));
    end

    // R6 masked latch then enable
    set_pin(0, 1'b0, 1'b1, 1'b0, 1'b0);
    pins[0] = 1'b0; step(4); ack_pin(0); step(1);
    pins[0] = 1'b1; step(4);
    chk(32'(irq[0]), 32'h0, "R6 disabled pin quiet");
    set_pin(0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(32'(irq[0]), 32'h1, "R6 latch shown after enable");

    // R9 edge latency
    pins[0] = 1'b0; step(4); ack_pin(0); step(1);
    pins[0] = 1'b1; step(2);
    chk(32'(irq[0]), 32'h0, "R9 edge not yet at edge 2");
    step(1);
    chk(32'(irq[0]), 32'h1, "R9 edge due at edge 3");

    // R9 level latency (pin 3 high level from table)
    pins[3] = 1'b0; step(4);
    pins[3] = 1'b1; step(1);
    chk(32'(irq[3]), 32'h0, "R9 level not yet at edge 1");
    step(1);
    chk(32'(irq[3]), 32'h1, "R9 level due at edge 2");

    // R8 ack in level mode
    ack_pin(3); step(2);
    chk(32'(irq[3]), 32'h1, "R8 ack ignored in level mode");

    // R7 ack only its own pin
    set_pin(1, 1'b0, 1'b1, 1'b0, 1'b1);
    pins[0] = 1'b0; pins[1] = 1'b0; step(4);
    ack_pin(0); ack_pin(1); step(1);
    pins[0] = 1'b1; pins[1] = 1'b1; step(4);
    ack_pin(0); step(1);
    chk(32'(irq[0]), 32'h0, "R7 acked pin cleared");
    chk(32'(irq[1]), 32'h1, "R7 other pin untouched");
    wr(0, img[0]); step(2);
    chk(32'(irq[1]), 32'h1, "R7 zero ack bit no effect");
    pins[1] = 1'b0; step(4);
    chk(32'(irq[1]), 32'h1, "R3 event held after pin returns");

    // R2 readback and word separation
    rd(0, v); chk(v, img[0], "R2 word0 readback");
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk(v, 32'h0003_3303, "R2 word1 unused slots and ack read 0");
    rd(0, v); chk(v, img[0], "R2 word0 unchanged by word1 write");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule